// File: doc/BRIEF.md
# Location-Indexed Residual Half-Line Store

This block keeps the second 32-byte half of 64-byte lines that a half-size last-level cache could not shrink to 32 bytes. The main cache keeps one half of such a line in its own 32-byte slot, and this block keeps the other half. Lookups here use the position the line holds in the main cache (its set number and way number), not the memory address. The low bits of the main-cache set select a set here. The remaining set bits, joined with the main-cache way, form the tag.

The two halves are not a plain low/high split. The sixteen 32-bit words of a line alternate between the halves, and a line-address bit picks which parity goes where. On an allocate, the block takes the full line. It returns at once the half that the main cache should keep and stores the other half. On a probe, the requester supplies the main-cache half. One cycle later the block answers with hit, the stored half, the line rebuilt in original word order, and a per-word mask of the valid words. A miss here is a partial hit, because the words from the main-cache half are still returned and marked valid.

When the main cache evicts a line, it drives the invalidate port so that the matching entry is removed. When this block replaces an entry, it says nothing to the main cache. Replacement within a set is true LRU.

Top module: `resid_half_store`

## Requirements
- R1: Let `alloc_abit` = 0. Then word k of `alloc_main_half` is word 2k of `alloc_line`, and the stored half holds words 2k+1. Let `alloc_abit` = 1. Then the roles swap: the main half takes words 2k+1 and the stored half takes words 2k. Word i occupies bits [32i+31:32i].
- R2: `rsp_vld` is high in exactly the cycles that follow a cycle with `probe_vld` high. The response reflects the contents as they stood before that clock edge.
- R3: A probe hits when a valid entry holds the same main-cache set and way. On a hit, `rsp_resid` is the stored half and `rsp_line` is the original line. Each word comes from the probe's main half or the stored half, as R1 assigns it. `rsp_present` is 16'hFFFF, with bit i standing for word i.
- R4: On a probe miss, `rsp_hit` is 0 and `rsp_resid` is zero. `rsp_line` carries the main-half words at their original positions and zero elsewhere. `rsp_present` is 16'h5555 when the probe's address bit is 0 and 16'hAAAA when it is 1.
- R5: The set index is the low IDX_BITS of the main-cache set. Entries whose sets share those low bits but differ in the high bits, or that differ in way, coexist in one set and never hit for each other.
- R6: An invalidate removes only the entry at the given main-cache set and way. Other entries remain, and an invalidate with no matching entry changes nothing.
- R7: An allocate to a location that is already present overwrites that entry in place with the new half.
- R8: When an allocate targets a full set, it replaces the least recently used way. Both allocates and probe hits make a way the most recently used.
- R9: After reset every entry is invalid and `rsp_vld` and `rsp_present` are zero.
- R10: An invalidate and an allocate to the same location in the same cycle leave the entry valid with the newly allocated half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_vld | input | 1 | Probe request |
| probe_set | input | SET_BITS | Main-cache set of the probed line |
| probe_way | input | WAY_BITS | Main-cache way of the probed line |
| probe_abit | input | 1 | Line-address bit selecting the interleave |
| probe_main_half | input | 256 | Half read from the main-cache slot |
| rsp_vld | output | 1 | Probe response valid |
| rsp_hit | output | 1 | Stored half found |
| rsp_resid | output | 256 | Stored half on hit, zero on miss |
| rsp_line | output | 512 | Line rebuilt in original word order |
| rsp_present | output | 16 | Per-word valid mask |
| alloc_vld | input | 1 | Allocate or rewrite an entry |
| alloc_set | input | SET_BITS | Main-cache set of the filled line |
| alloc_way | input | WAY_BITS | Main-cache way of the filled line |
| alloc_abit | input | 1 | Line-address bit selecting the interleave |
| alloc_line | input | 512 | Full uncompressed line |
| alloc_main_half | output | 256 | Half the main cache should keep |
| inv_vld | input | 1 | Main-cache eviction notice |
| inv_set | input | SET_BITS | Main-cache set of the evicted line |
| inv_way | input | WAY_BITS | Main-cache way of the evicted line |

## Verification
The checker watches four things on every cycle. It checks the one-cycle link from probe to response, and that the valid-word mask is full on a hit and covers exactly half the line on a miss. It also checks that a probe following an invalidate of its location misses, and that a probe following an allocate of its location hits. Some behaviour only the bench's scenarios can show. These are the word interleave for both address-bit values, tag separation within a shared set, in-place rewrites, LRU victim choice after a probe hit, and the same-cycle invalidate/allocate order.

// File: rtl/resid_half_store.sv
module resid_half_store #(
  parameter int SET_BITS   = 8,
  parameter int WAY_BITS   = 2,
  parameter int IDX_BITS   = 4,
  parameter int WAYS       = 4,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               probe_vld,
  input  logic [SET_BITS-1:0]                probe_set,
  input  logic [WAY_BITS-1:0]                probe_way,
  input  logic                               probe_abit,
  input  logic [LINE_WORDS/2*WORD_W-1:0]     probe_main_half,
  output logic                               rsp_vld,
  output logic                               rsp_hit,
  output logic [LINE_WORDS/2*WORD_W-1:0]     rsp_resid,
  output logic [LINE_WORDS*WORD_W-1:0]       rsp_line,
  output logic [LINE_WORDS-1:0]              rsp_present,
  input  logic                               alloc_vld,
  input  logic [SET_BITS-1:0]                alloc_set,
  input  logic [WAY_BITS-1:0]                alloc_way,
  input  logic                               alloc_abit,
  input  logic [LINE_WORDS*WORD_W-1:0]       alloc_line,
  output logic [LINE_WORDS/2*WORD_W-1:0]     alloc_main_half,
  input  logic                               inv_vld,
  input  logic [SET_BITS-1:0]                inv_set,
  input  logic [WAY_BITS-1:0]                inv_way
);
  localparam int HALF_WORDS = LINE_WORDS / 2;
  localparam int HALF_W     = HALF_WORDS * WORD_W;
  localparam int SETS       = 1 << IDX_BITS;
  localparam int TAG_W      = SET_BITS - IDX_BITS + WAY_BITS;
  localparam int SEL_W      = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]   vld_q [SETS];
  logic [SEL_W-1:0]  age_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [HALF_W-1:0] dat_q [SETS][WAYS];

  logic              rsp_vld_q, rsp_hit_q, rsp_abit_q;
  logic [HALF_W-1:0] rsp_main_q, rsp_res_q;

  wire [IDX_BITS-1:0] p_idx = probe_set[IDX_BITS-1:0];
  wire [IDX_BITS-1:0] a_idx = alloc_set[IDX_BITS-1:0];
  wire [IDX_BITS-1:0] i_idx = inv_set[IDX_BITS-1:0];
  wire [TAG_W-1:0]    p_tag = {probe_set[SET_BITS-1:IDX_BITS], probe_way};
  wire [TAG_W-1:0]    a_tag = {alloc_set[SET_BITS-1:IDX_BITS], alloc_way};
  wire [TAG_W-1:0]    i_tag = {inv_set[SET_BITS-1:IDX_BITS], inv_way};

  logic              p_hit, a_match, a_free, i_hit;
  logic [SEL_W-1:0]  p_way, a_mway, a_fway, a_lway, a_way, i_way;
  logic [HALF_W-1:0] p_data, a_res;

  always_comb begin
    p_hit = 1'b0; p_way = '0; p_data = '0;
    a_match = 1'b0; a_mway = '0; a_lway = '0;
    i_hit = 1'b0; i_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[p_idx][w] && tag_q[p_idx][w] == p_tag) begin
        p_hit = 1'b1; p_way = SEL_W'(w); p_data = dat_q[p_idx][w];
      end
      if (vld_q[a_idx][w] && tag_q[a_idx][w] == a_tag) begin
        a_match = 1'b1; a_mway = SEL_W'(w);
      end
      if (age_q[a_idx][w] == SEL_W'(WAYS - 1)) a_lway = SEL_W'(w);
      if (vld_q[i_idx][w] && tag_q[i_idx][w] == i_tag) begin
        i_hit = 1'b1; i_way = SEL_W'(w);
      end
    end
    a_free = 1'b0; a_fway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[a_idx][w]) begin
        a_free = 1'b1; a_fway = SEL_W'(w);
      end
    end
    a_way = a_match ? a_mway : (a_free ? a_fway : a_lway);
  end

  wire p_touch = probe_vld && p_hit && !(alloc_vld && a_idx == p_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= SEL_W'(w);
      end
      rsp_vld_q <= 1'b0;
      rsp_hit_q <= 1'b0;
    end else begin
      if (inv_vld && i_hit) vld_q[i_idx][i_way] <= 1'b0;
      if (alloc_vld) begin
        vld_q[a_idx][a_way] <= 1'b1;
        for (int w = 0; w < WAYS; w++) begin
          if (w == int'(a_way))
            age_q[a_idx][w] <= '0;
          else if (age_q[a_idx][w] < age_q[a_idx][a_way])
            age_q[a_idx][w] <= age_q[a_idx][w] + 1'b1;
        end
      end
      if (p_touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (w == int'(p_way))
            age_q[p_idx][w] <= '0;
          else if (age_q[p_idx][w] < age_q[p_idx][p_way])
            age_q[p_idx][w] <= age_q[p_idx][w] + 1'b1;
        end
      end
      rsp_vld_q <= probe_vld;
      rsp_hit_q <= probe_vld && p_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_vld) begin
      tag_q[a_idx][a_way] <= a_tag;
      dat_q[a_idx][a_way] <= a_res;
    end
    if (probe_vld) begin
      rsp_main_q <= probe_main_half;
      rsp_res_q  <= p_data;
      rsp_abit_q <= probe_abit;
    end
  end

  wire [HALF_W-1:0] res_out = rsp_hit_q ? rsp_res_q : '0;

  for (genvar k = 0; k < HALF_WORDS; k++) begin : g_weave
    wire [WORD_W-1:0] ev = alloc_line[(2*k)*WORD_W +: WORD_W];
    wire [WORD_W-1:0] od = alloc_line[(2*k+1)*WORD_W +: WORD_W];
    wire [WORD_W-1:0] mw = rsp_main_q[k*WORD_W +: WORD_W];
    wire [WORD_W-1:0] rw = res_out[k*WORD_W +: WORD_W];
    assign alloc_main_half[k*WORD_W +: WORD_W] = alloc_abit ? od : ev;
    assign a_res[k*WORD_W +: WORD_W]           = alloc_abit ? ev : od;
    assign rsp_line[(2*k)*WORD_W +: WORD_W]    = rsp_abit_q ? rw : mw;
    assign rsp_line[(2*k+1)*WORD_W +: WORD_W]  = rsp_abit_q ? mw : rw;
    assign rsp_present[2*k]   = rsp_vld_q && (rsp_hit_q || !rsp_abit_q);
    assign rsp_present[2*k+1] = rsp_vld_q && (rsp_hit_q || rsp_abit_q);
  end

  assign rsp_vld   = rsp_vld_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_resid = res_out;
endmodule

module resid_half_store_chk #(
  parameter int SET_BITS   = 8,
  parameter int WAY_BITS   = 2,
  parameter int LINE_WORDS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  probe_vld,
  input logic [SET_BITS-1:0]   probe_set,
  input logic [WAY_BITS-1:0]   probe_way,
  input logic                  alloc_vld,
  input logic [SET_BITS-1:0]   alloc_set,
  input logic [WAY_BITS-1:0]   alloc_way,
  input logic                  inv_vld,
  input logic [SET_BITS-1:0]   inv_set,
  input logic [WAY_BITS-1:0]   inv_way,
  input logic                  rsp_vld,
  input logic                  rsp_hit,
  input logic [LINE_WORDS-1:0] rsp_present
);
  AST_RSP_AFTER_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    probe_vld |=> rsp_vld); // R2
  AST_NO_RSP_WITHOUT_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_vld |=> !rsp_vld); // R2
  AST_FULL_MASK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_hit) |-> (&rsp_present)); // R3
  AST_HALF_MASK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_hit) |-> ($countones(rsp_present) == LINE_WORDS / 2)); // R4
  AST_MISS_AFTER_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_vld && $past(inv_vld) && !$past(alloc_vld) &&
     probe_set == $past(inv_set) && probe_way == $past(inv_way)) |=> !rsp_hit); // R6
  AST_HIT_AFTER_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_vld && $past(alloc_vld) &&
     probe_set == $past(alloc_set) && probe_way == $past(alloc_way)) |=> rsp_hit); // R10
endmodule

bind resid_half_store resid_half_store_chk #(
  .SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .probe_vld(probe_vld), .probe_set(probe_set), .probe_way(probe_way),
  .alloc_vld(alloc_vld), .alloc_set(alloc_set), .alloc_way(alloc_way),
  .inv_vld(inv_vld), .inv_set(inv_set), .inv_way(inv_way),
  .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_present(rsp_present)
);

// File: tb/resid_half_store_tb.sv
module resid_half_store_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OP_ALLOC = 0, OP_PROBE = 1, OP_INV = 2;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         probe_vld = 0, probe_abit = 0, alloc_vld = 0, alloc_abit = 0, inv_vld = 0;
  logic [7:0]   probe_set = 0, alloc_set = 0, inv_set = 0;
  logic [1:0]   probe_way = 0, alloc_way = 0, inv_way = 0;
  logic [255:0] probe_main_half = 0;
  logic [511:0] alloc_line = 0;
  logic         rsp_vld, rsp_hit;
  logic [255:0] rsp_resid, alloc_main_half;
  logic [511:0] rsp_line;
  logic [15:0]  rsp_present;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  resid_half_store u_dut (
    .clk(clk), .rst_n(rst_n),
    .probe_vld(probe_vld), .probe_set(probe_set), .probe_way(probe_way),
    .probe_abit(probe_abit), .probe_main_half(probe_main_half),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_resid(rsp_resid),
    .rsp_line(rsp_line), .rsp_present(rsp_present),
    .alloc_vld(alloc_vld), .alloc_set(alloc_set), .alloc_way(alloc_way),
    .alloc_abit(alloc_abit), .alloc_line(alloc_line), .alloc_main_half(alloc_main_half),
    .inv_vld(inv_vld), .inv_set(inv_set), .inv_way(inv_way)
  );

  // entry: op[17:16] set[15:8] way[7:6] abit[5] exp_hit[4] seed[3:0]
  localparam int NV = 26;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h03, 2'd1, 1'b0, 1'b0, 4'd1},  // R1 alloc
    {2'd1, 8'h03, 2'd1, 1'b0, 1'b1, 4'd1},  // R3 hit
    {2'd1, 8'h13, 2'd1, 1'b0, 1'b0, 4'd1},  // R5 same index, other tag
    {2'd0, 8'h13, 2'd1, 1'b1, 1'b0, 4'd2},  // R1 odd-word split
    {2'd1, 8'h13, 2'd1, 1'b1, 1'b1, 4'd2},  // R3
    {2'd1, 8'h03, 2'd1, 1'b0, 1'b1, 4'd1},  // R5 coexist
    {2'd1, 8'h03, 2'd2, 1'b0, 1'b0, 4'd1},  // R5 way differs
    {2'd2, 8'h03, 2'd1, 1'b0, 1'b0, 4'd0},  // R6 invalidate
    {2'd1, 8'h03, 2'd1, 1'b0, 1'b0, 4'd1},  // R6 gone, R4 partial
    {2'd1, 8'h13, 2'd1, 1'b1, 1'b1, 4'd2},  // R6 neighbour kept
    {2'd2, 8'h23, 2'd0, 1'b0, 1'b0, 4'd0},  // R6 no match
    {2'd1, 8'h13, 2'd1, 1'b1, 1'b1, 4'd2},  // R6
    {2'd0, 8'h13, 2'd1, 1'b1, 1'b0, 4'd3},  // R7 rewrite
    {2'd1, 8'h13, 2'd1, 1'b1, 1'b1, 4'd3},  // R7 new data
    {2'd0, 8'h03, 2'd0, 1'b0, 1'b0, 4'd4},  // R7 fill rest of set
    {2'd0, 8'h23, 2'd0, 1'b1, 1'b0, 4'd5},
    {2'd0, 8'h33, 2'd0, 1'b0, 1'b0, 4'd6},
    {2'd1, 8'h13, 2'd1, 1'b1, 1'b1, 4'd3},  // R7 single copy kept
    {2'd0, 8'h07, 2'd0, 1'b0, 1'b0, 4'd1},  // R8 fill index 7
    {2'd0, 8'h17, 2'd0, 1'b0, 1'b0, 4'd2},
    {2'd0, 8'h27, 2'd0, 1'b0, 1'b0, 4'd3},
    {2'd0, 8'h37, 2'd0, 1'b0, 1'b0, 4'd4},
    {2'd1, 8'h07, 2'd0, 1'b0, 1'b1, 4'd1},  // R8 probe hit refreshes 0x07
    {2'd0, 8'h47, 2'd0, 1'b0, 1'b0, 4'd5},  // R8 evicts 0x17
    {2'd1, 8'h17, 2'd0, 1'b0, 1'b0, 4'd2},  // R8 victim missing
    {2'd1, 8'h07, 2'd0, 1'b0, 1'b1, 4'd1}   // R8 refreshed way kept
  };

  function automatic logic [511:0] mk_line(logic [7:0] s, logic [1:0] w, logic [3:0] seed);
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = {seed, 4'(i), s, 6'(w), 10'h2B5};
    return l;
  endfunction

  function automatic logic [255:0] half_of(logic [511:0] l, int parity);
    logic [255:0] h;
    for (int k = 0; k < 8; k++) h[k*32 +: 32] = l[(2*k+parity)*32 +: 32];
    return h;
  endfunction

  task automatic check(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(int op, logic [7:0] s, logic [1:0] w, logic ab, logic eh, logic [3:0] seed);
    logic [511:0] l = mk_line(s, w, seed);
    logic [511:0] el;
    logic [15:0]  ep;
    @(negedge clk);
    case (op)
      OP_ALLOC: begin alloc_vld = 1; alloc_set = s; alloc_way = w; alloc_abit = ab; alloc_line = l; end
      OP_PROBE: begin probe_vld = 1; probe_set = s; probe_way = w; probe_abit = ab;
                      probe_main_half = half_of(l, int'(ab)); end
      default:  begin inv_vld = 1; inv_set = s; inv_way = w; end
    endcase
    #1;
    if (op == OP_ALLOC)
      check(alloc_main_half == half_of(l, int'(ab)), "R1", "main half", 512'(alloc_main_half),
            512'(half_of(l, int'(ab))));
    @(negedge clk);
    alloc_vld = 0; probe_vld = 0; inv_vld = 0;
    check(rsp_vld == (op == OP_PROBE), "R2", "rsp_vld", 512'(rsp_vld), 512'(op == OP_PROBE));
    if (op == OP_PROBE) begin
      el = l; ep = 16'hFFFF;
      if (!eh) begin
        ep = ab ? 16'hAAAA : 16'h5555;
        for (int i = 0; i < 16; i++) if ((i % 2) != int'(ab)) el[i*32 +: 32] = '0;
      end
      check(rsp_hit == eh, eh ? "R3" : "R4", "hit", 512'(rsp_hit), 512'(eh));
      check(rsp_line == el, eh ? "R3" : "R4", "line", rsp_line, el);
      check(rsp_present == ep, eh ? "R3" : "R4", "present", 512'(rsp_present), 512'(ep));
      check(rsp_resid == (eh ? half_of(l, 1 - int'(ab)) : '0), eh ? "R3" : "R4", "resid",
            512'(rsp_resid), 512'(eh ? half_of(l, 1 - int'(ab)) : '0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rsp_vld == 0, "R9", "rsp_vld after reset", 512'(rsp_vld), 512'(0));
    check(rsp_present == 0, "R9", "present after reset", 512'(rsp_present), 512'(0));
    run_op(OP_PROBE, 8'h05, 2'd0, 1'b0, 1'b0, 4'd0); // R9 empty after reset
    run_op(OP_PROBE, 8'h05, 2'd0, 1'b1, 1'b0, 4'd0); // R4 odd-parity mask
    for (int v = 0; v < NV; v++)
      run_op(int'(VEC[v][17:16]), VEC[v][15:8], VEC[v][7:6], VEC[v][5], VEC[v][4], VEC[v][3:0]);
    run_op(OP_PROBE, 8'h27, 2'd0, 1'b0, 1'b1, 4'd3);  // R8
    run_op(OP_PROBE, 8'h47, 2'd0, 1'b0, 1'b1, 4'd5);  // R8
    run_op(OP_ALLOC, 8'h09, 2'd3, 1'b1, 1'b0, 4'd7);
    // R10: invalidate and allocate the same location in one cycle
    @(negedge clk);
    inv_vld = 1; inv_set = 8'h09; inv_way = 2'd3;
    alloc_vld = 1; alloc_set = 8'h09; alloc_way = 2'd3; alloc_abit = 1;
    alloc_line = mk_line(8'h09, 2'd3, 4'd8);
    @(negedge clk);
    inv_vld = 0; alloc_vld = 0;
    run_op(OP_PROBE, 8'h09, 2'd3, 1'b1, 1'b1, 4'd8); // R10 survives with new half
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule